// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation structure in memory: a directory of 1024 entries selected by the top ten address bits, and tables of 1024 entries selected by the next ten. A directory entry can also map a 4 MB region directly when large pages are enabled. The walker fetches entries one at a time over a single-outstanding memory port. It applies user and write rights taken from both levels. It writes entries back only when their accessed or dirty flags must change.

A requester presents a virtual address with write and user qualifiers. Each request ends in exactly one response. A done response carries the physical address, a write-grant bit and a large-page flag. A fault response carries a three-bit error code, and the faulting address is held on a dedicated output until the next fault. Control inputs supply paging enable, supervisor write protection, the directory base, large-page enable and an address mask that is applied to every generated address.

Top module: `vxlate_walker`

## Requirements
- R1: With `cfg_paging` low the response comes without any memory access: `rsp_pa` = `req_va & cfg_a20_mask`, `rsp_perm_w` = 1 and `rsp_big` = 0.
- R2: The first fetch reads the directory entry at ((`cfg_root` with bits 11:0 cleared) + va[31:22]*4) & `cfg_a20_mask`.
- R3: On the small-page path the second fetch reads the table entry at ((directory entry with bits 11:0 cleared) + va[21:12]*4) & `cfg_a20_mask`, and `rsp_pa` = {entry[31:12], va[11:0]} & mask.
- R4: A fetched entry with bit 0 (present) clear gives a fault with `rsp_ecode[0]` = 0, `rsp_ecode[1]` = write and `rsp_ecode[2]` = user, and `rsp_fault_va` takes the request address.
- R5: A directory entry with bit 7 set while `cfg_big_en` is high maps a 4 MB page: no table fetch, `rsp_pa` = {entry[31:22], va[21:0]} & mask and `rsp_big` = 1. With `cfg_big_en` low, bit 7 is ignored and the entry points to a table.
- R6: Small-page rights are the AND of both levels in bit 2 (user) and bit 1 (read/write). A user access faults if the user right is clear, or if it is a write and the write right is clear. Such faults set `rsp_ecode[0]` = 1.
- R7: A supervisor write to a page without the write right faults only while `cfg_wp` is high.
- R8: On the small-page path a directory entry with bit 5 (accessed) clear is written back with bit 5 set before the table fetch. A directory entry with bit 5 set is not written.
- R9: The final entry is written back with bit 5 set, and with bit 6 (dirty) also set on a write. The write-back is issued only if this changes the entry.
- R10: `rsp_perm_w` is 1 only when the final entry, after its update, has bit 6 set and the rights allow a write for the requester (user: write right; supervisor: write right or `cfg_wp` low).
- R11: A memory request holds address, data and direction until `mem_ready`. `req_ready` is high only while idle, and each accepted request yields exactly one of `rsp_done` or `rsp_fault` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| cfg_paging | input | 1 | Paging enable |
| cfg_wp | input | 1 | Supervisor write protection |
| cfg_root | input | 32 | Directory base address |
| cfg_big_en | input | 1 | 4 MB page enable |
| cfg_a20_mask | input | 32 | Mask ANDed onto every generated address |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Updated entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read entry |
| rsp_done | output | 1 | Translation succeeded (one cycle) |
| rsp_fault | output | 1 | Translation faulted (one cycle) |
| rsp_pa | output | 32 | Physical address |
| rsp_perm_w | output | 1 | Write permitted for cached use |
| rsp_big | output | 1 | Mapping is a 4 MB page |
| rsp_ecode | output | 3 | Fault code: protection, write, user |
| rsp_fault_va | output | 32 | Last faulting virtual address |

## Verification
The bench uses the default package geometry: 12 offset bits and 10 index bits per level, with 32-bit entries. A sparse memory model behind the port adds one cycle of read latency, and in some scenarios `mem_ready` toggles every cycle, so the walker must hold its request across stalls. With this geometry the bench can write exact directory and table indices by hand. It can also fold a directory base onto another by clearing address bit 20 in the mask. Large and small pages can share one directory, so the same entry is read under both values of `cfg_big_en`.

// File: rtl/vxlate_pkg.sv
package vxlate_pkg;
  localparam int ENT_W  = 32;
  localparam int OFS_W  = 12;
  localparam int IDX_W  = 10;
  localparam int BIG_W  = OFS_W + IDX_W;
  localparam int ECODE_W = 3;

  localparam int B_PRES = 0;
  localparam int B_RW   = 1;
  localparam int B_USR  = 2;
  localparam int B_ACC  = 5;
  localparam int B_DRT  = 6;
  localparam int B_PS   = 7;

  typedef enum logic [3:0] {
    S_IDLE, S_RDIR, S_WDIR, S_CHKD, S_WBD,
    S_RTBL, S_WTBL, S_CHKT, S_WBT, S_OK, S_FLT
  } walk_st_e;

  function automatic logic [ENT_W-1:0] entry_addr(
    input logic [ENT_W-1:0] base,
    input logic [IDX_W-1:0] idx,
    input logic [ENT_W-1:0] mask);
    logic [ENT_W-1:0] sum;
    sum = {base[ENT_W-1:OFS_W], {OFS_W{1'b0}}}
        + {{(ENT_W-IDX_W-2){1'b0}}, idx, 2'b00};
    return sum & mask;
  endfunction

  function automatic logic rights_ok(input logic u_r, input logic rw_r,
                                     input logic is_user, input logic is_wr,
                                     input logic wp);
    if (is_user) return u_r && (!is_wr || rw_r);
    return !(is_wr && wp && !rw_r);
  endfunction

  function automatic logic grant_wr(input logic dirty, input logic rw_r,
                                    input logic is_user, input logic wp);
    if (is_user) return dirty && rw_r;
    return dirty && (!wp || rw_r);
  endfunction

  function automatic logic [ECODE_W-1:0] fault_code(input logic prot,
                                                    input logic is_wr,
                                                    input logic is_user);
    return {is_user, is_wr, prot};
  endfunction
endpackage

// File: rtl/vxlate_addr.sv
module vxlate_addr
  import vxlate_pkg::*;
(
  input  logic [ENT_W-1:0] va,
  input  logic [ENT_W-1:0] root,
  input  logic [ENT_W-1:0] pde,
  input  logic [ENT_W-1:0] pte,
  input  logic [ENT_W-1:0] mask,
  output logic [ENT_W-1:0] dir_addr,
  output logic [ENT_W-1:0] tbl_addr,
  output logic [ENT_W-1:0] pa_flat,
  output logic [ENT_W-1:0] pa_small,
  output logic [ENT_W-1:0] pa_big
);
  always_comb begin
    dir_addr = entry_addr(root, va[ENT_W-1:BIG_W], mask);
    tbl_addr = entry_addr(pde, va[BIG_W-1:OFS_W], mask);
    pa_flat  = va & mask;
    pa_small = {pte[ENT_W-1:OFS_W], va[OFS_W-1:0]} & mask;
    pa_big   = {pde[ENT_W-1:BIG_W], va[BIG_W-1:0]} & mask;
  end
endmodule

// File: rtl/vxlate_rights.sv
module vxlate_rights
  import vxlate_pkg::*;
(
  input  logic [ENT_W-1:0] pde,
  input  logic [ENT_W-1:0] pte,
  input  logic             dir_final,
  input  logic             is_user,
  input  logic             is_wr,
  input  logic             wp,
  output logic             viol,
  output logic             wr_grant,
  output logic [ENT_W-1:0] new_ent,
  output logic             need_wb
);
  logic [ENT_W-1:0] fin;
  logic u_r, rw_r;

  always_comb begin
    fin  = dir_final ? pde : pte;
    u_r  = dir_final ? pde[B_USR] : (pde[B_USR] & pte[B_USR]);
    rw_r = dir_final ? pde[B_RW]  : (pde[B_RW]  & pte[B_RW]);
    viol = !rights_ok(u_r, rw_r, is_user, is_wr, wp);
    new_ent = fin;
    new_ent[B_ACC] = 1'b1;
    if (is_wr) new_ent[B_DRT] = 1'b1;
    need_wb  = (new_ent != fin);
    wr_grant = grant_wr(new_ent[B_DRT], rw_r, is_user, wp);
  end
endmodule

// File: rtl/vxlate_fsm.sv
module vxlate_fsm
  import vxlate_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ENT_W-1:0]   req_va,
  input  logic               req_write,
  input  logic               req_user,
  input  logic               cfg_paging,
  input  logic               cfg_big_en,
  input  logic               mem_ready,
  input  logic               mem_rvalid,
  input  logic [ENT_W-1:0]   mem_rdata,
  input  logic [ENT_W-1:0]   dir_addr,
  input  logic [ENT_W-1:0]   tbl_addr,
  input  logic [ENT_W-1:0]   pa_flat,
  input  logic [ENT_W-1:0]   pa_small,
  input  logic [ENT_W-1:0]   pa_big,
  input  logic               viol,
  input  logic               wr_grant,
  input  logic [ENT_W-1:0]   new_ent,
  input  logic               need_wb,
  output walk_st_e           st,
  output logic [ENT_W-1:0]   va_q,
  output logic               wr_q,
  output logic               usr_q,
  output logic [ENT_W-1:0]   pde_q,
  output logic [ENT_W-1:0]   pte_q,
  output logic [ENT_W-1:0]   maddr_q,
  output logic [ENT_W-1:0]   mwdata_q,
  output logic               mwe_q,
  output logic [ENT_W-1:0]   pa_q,
  output logic               permw_q,
  output logic               big_q,
  output logic [ECODE_W-1:0] ecode_q,
  output logic [ENT_W-1:0]   fva_q
);
  logic big_path;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; va_q <= '0; wr_q <= 1'b0; usr_q <= 1'b0;
      pde_q <= '0; pte_q <= '0; maddr_q <= '0; mwdata_q <= '0;
      mwe_q <= 1'b0; pa_q <= '0; permw_q <= 1'b0; big_q <= 1'b0;
      ecode_q <= '0; fva_q <= '0; big_path <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_va; wr_q <= req_write; usr_q <= req_user;
          if (!cfg_paging) begin
            pa_q <= pa_flat; permw_q <= 1'b1; big_q <= 1'b0;
            st <= S_OK;
          end else begin
            maddr_q <= dir_addr; mwe_q <= 1'b0;
            st <= S_RDIR;
          end
        end
        S_RDIR: if (mem_ready) st <= S_WDIR;
        S_WDIR: if (mem_rvalid) begin
          pde_q <= mem_rdata; st <= S_CHKD;
        end
        S_CHKD: begin
          if (!pde_q[B_PRES]) begin
            ecode_q <= fault_code(1'b0, wr_q, usr_q); fva_q <= va_q;
            st <= S_FLT;
          end else if (pde_q[B_PS] && cfg_big_en) begin
            big_path <= 1'b1;
            if (viol) begin
              ecode_q <= fault_code(1'b1, wr_q, usr_q); fva_q <= va_q;
              st <= S_FLT;
            end else begin
              pa_q <= pa_big; permw_q <= wr_grant; big_q <= 1'b1;
              if (need_wb) begin
                mwe_q <= 1'b1; mwdata_q <= new_ent; st <= S_WBD;
              end else st <= S_OK;
            end
          end else begin
            big_path <= 1'b0;
            if (!pde_q[B_ACC]) begin
              mwe_q <= 1'b1; mwdata_q <= pde_q | (ENT_W'(1) << B_ACC);
              st <= S_WBD;
            end else begin
              maddr_q <= tbl_addr; mwe_q <= 1'b0; st <= S_RTBL;
            end
          end
        end
        S_WBD: if (mem_ready) begin
          if (big_path) st <= S_OK;
          else begin
            maddr_q <= tbl_addr; mwe_q <= 1'b0; st <= S_RTBL;
          end
        end
        S_RTBL: if (mem_ready) st <= S_WTBL;
        S_WTBL: if (mem_rvalid) begin
          pte_q <= mem_rdata; st <= S_CHKT;
        end
        S_CHKT: begin
          if (!pte_q[B_PRES]) begin
            ecode_q <= fault_code(1'b0, wr_q, usr_q); fva_q <= va_q;
            st <= S_FLT;
          end else if (viol) begin
            ecode_q <= fault_code(1'b1, wr_q, usr_q); fva_q <= va_q;
            st <= S_FLT;
          end else begin
            pa_q <= pa_small; permw_q <= wr_grant; big_q <= 1'b0;
            if (need_wb) begin
              mwe_q <= 1'b1; mwdata_q <= new_ent; st <= S_WBT;
            end else st <= S_OK;
          end
        end
        S_WBT: if (mem_ready) st <= S_OK;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vxlate_walker.sv
module vxlate_walker
  import vxlate_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ENT_W-1:0]   req_va,
  input  logic               req_write,
  input  logic               req_user,
  input  logic               cfg_paging,
  input  logic               cfg_wp,
  input  logic [ENT_W-1:0]   cfg_root,
  input  logic               cfg_big_en,
  input  logic [ENT_W-1:0]   cfg_a20_mask,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic               mem_we,
  output logic [ENT_W-1:0]   mem_addr,
  output logic [ENT_W-1:0]   mem_wdata,
  input  logic               mem_rvalid,
  input  logic [ENT_W-1:0]   mem_rdata,
  output logic               rsp_done,
  output logic               rsp_fault,
  output logic [ENT_W-1:0]   rsp_pa,
  output logic               rsp_perm_w,
  output logic               rsp_big,
  output logic [ECODE_W-1:0] rsp_ecode,
  output logic [ENT_W-1:0]   rsp_fault_va
);
  walk_st_e st;
  logic [ENT_W-1:0] va_q, pde_q, pte_q, va_cur;
  logic wr_q, usr_q;
  logic [ENT_W-1:0] dir_addr, tbl_addr, pa_flat, pa_small, pa_big, new_ent;
  logic viol, wr_grant, need_wb;

  // named events for the checker
  logic walk_accept;
  assign walk_accept = req_valid && req_ready;

  assign va_cur = (st == S_IDLE) ? req_va : va_q;

  vxlate_addr u_addr (
    .va(va_cur), .root(cfg_root), .pde(pde_q), .pte(pte_q),
    .mask(cfg_a20_mask), .dir_addr(dir_addr), .tbl_addr(tbl_addr),
    .pa_flat(pa_flat), .pa_small(pa_small), .pa_big(pa_big)
  );

  vxlate_rights u_rights (
    .pde(pde_q), .pte(pte_q), .dir_final(st == S_CHKD),
    .is_user(usr_q), .is_wr(wr_q), .wp(cfg_wp),
    .viol(viol), .wr_grant(wr_grant), .new_ent(new_ent), .need_wb(need_wb)
  );

  vxlate_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_write(req_write), .req_user(req_user), .cfg_paging(cfg_paging),
    .cfg_big_en(cfg_big_en), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .dir_addr(dir_addr), .tbl_addr(tbl_addr),
    .pa_flat(pa_flat), .pa_small(pa_small), .pa_big(pa_big),
    .viol(viol), .wr_grant(wr_grant), .new_ent(new_ent), .need_wb(need_wb),
    .st(st), .va_q(va_q), .wr_q(wr_q), .usr_q(usr_q), .pde_q(pde_q),
    .pte_q(pte_q), .maddr_q(mem_addr), .mwdata_q(mem_wdata), .mwe_q(mem_we),
    .pa_q(rsp_pa), .permw_q(rsp_perm_w), .big_q(rsp_big),
    .ecode_q(rsp_ecode), .fva_q(rsp_fault_va)
  );

  assign req_ready = (st == S_IDLE);
  assign mem_valid = (st == S_RDIR) || (st == S_WBD) ||
                     (st == S_RTBL) || (st == S_WBT);
  assign rsp_done  = (st == S_OK);
  assign rsp_fault = (st == S_FLT);
endmodule

// File: rtl/vxlate_chk.sv
module vxlate_chk
  import vxlate_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               walk_accept,
  input logic               req_ready,
  input logic               req_write,
  input logic               req_user,
  input logic               mem_valid,
  input logic               mem_ready,
  input logic               mem_we,
  input logic [ENT_W-1:0]   mem_addr,
  input logic [ENT_W-1:0]   mem_wdata,
  input logic [ENT_W-1:0]   cfg_a20_mask,
  input logic               rsp_done,
  input logic               rsp_fault,
  input logic [ECODE_W-1:0] rsp_ecode
);
  logic seen_wr, seen_usr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_wr <= 1'b0; seen_usr <= 1'b0;
    end else if (walk_accept) begin
      seen_wr <= req_write; seen_usr <= req_user;
    end
  end

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                $stable(mem_we) && $stable(mem_wdata));
  // R11
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_accept |=> !req_ready);
  // R11
  one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_done && rsp_fault));
  // R4
  ecode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_ecode[2:1] == {seen_usr, seen_wr});
  // R9
  wb_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> mem_wdata[B_ACC]);
  // R2
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr & ~cfg_a20_mask) == '0);
endmodule

bind vxlate_walker vxlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .walk_accept(walk_accept), .req_ready(req_ready),
  .req_write(req_write), .req_user(req_user), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .cfg_a20_mask(cfg_a20_mask), .rsp_done(rsp_done),
  .rsp_fault(rsp_fault), .rsp_ecode(rsp_ecode)
);

// File: tb/sim_vxlate_walker.sv
`timescale 1ns/1ps
module sim_vxlate_walker;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_write = 0, req_user = 0, req_ready;
  logic [31:0] req_va = 0;
  logic cfg_paging = 0, cfg_wp = 0, cfg_big_en = 0;
  logic [31:0] cfg_root = 32'h0001_0000, cfg_a20_mask = 32'hFFFF_FFFF;
  logic mem_valid, mem_we, mem_ready = 0, mem_rvalid = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic rsp_done, rsp_fault, rsp_perm_w, rsp_big;
  logic [31:0] rsp_pa, rsp_fault_va;
  logic [2:0] rsp_ecode;

  vxlate_walker u0 (.*);

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_log [0:7];
  int rd_n = 0, wr_n = 0;
  logic [31:0] last_wa = 0, last_wd = 0;
  logic stall = 0, pend = 0;
  logic [31:0] pend_a = 0;
  logic got_done, got_fault;

  // memory model
  initial forever begin
    @(posedge clk);
    mem_rvalid <= 1'b0;
    mem_ready <= stall ? ~mem_ready : 1'b1;
    if (pend) begin
      mem_rvalid <= 1'b1;
      mem_rdata <= mem.exists(pend_a) ? mem[pend_a] : 32'h0;
      pend <= 1'b0;
    end
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr] = mem_wdata; wr_n++; last_wa = mem_addr; last_wd = mem_wdata;
      end else begin
        pend <= 1'b1; pend_a <= mem_addr;
        if (rd_n < 8) rd_log[rd_n] = mem_addr;
        rd_n++;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog: act=hung exp=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dir_at(input logic [31:0] root, input logic [31:0] va);
    return {root[31:12], va[31:22], 2'b00};
  endfunction

  task automatic xlate(input logic [31:0] va, input logic w, input logic u);
    int t = 0;
    rd_n = 0;
    @(negedge clk);
    req_va = va; req_write = w; req_user = u; req_valid = 1;
    @(posedge clk);
    #1 req_valid = 0;
    @(negedge clk);
    chk("R11 busy req_ready", {31'b0, req_ready}, 32'h0);
    got_done = rsp_done; got_fault = rsp_fault;
    while (!got_done && !got_fault && t < 200) begin
      @(negedge clk); t++;
      got_done = rsp_done; got_fault = rsp_fault;
    end
  endtask

  task automatic t_reset;
    chk("R11 reset req_ready", {31'b0, req_ready}, 32'h1);
    chk("R11 reset outputs", {29'b0, mem_valid, rsp_done, rsp_fault}, 32'h0);
  endtask

  task automatic t_flat;
    cfg_paging = 0;
    xlate(32'h1234_5678, 1'b1, 1'b1);
    chk("R1 done", {31'b0, got_done}, 1);
    chk("R1 pa", rsp_pa, 32'h1234_5678);
    chk("R1 perm/big", {30'b0, rsp_perm_w, rsp_big}, 32'h2);
    chk("R1 no fetch", rd_n, 0);
    cfg_a20_mask = ~(32'h1 << 20);
    xlate(32'h0010_0ABC, 1'b0, 1'b0);
    chk("R1 masked pa", rsp_pa, 32'h0000_0ABC);
    cfg_a20_mask = 32'hFFFF_FFFF;
  endtask

  task automatic t_small;
    int w0;
    cfg_paging = 1; stall = 1;
    mem[32'h0001_0004] = 32'h0002_0027;
    mem[32'h0002_000C] = 32'h0005_5007;
    w0 = wr_n;
    xlate(32'h0040_3123, 1'b0, 1'b1);
    chk("R3 done", {31'b0, got_done}, 1);
    chk("R2 dir addr", rd_log[0], dir_at(cfg_root, 32'h0040_3123));
    chk("R3 tbl addr", rd_log[1], 32'h0002_000C);
    chk("R3 pa", rsp_pa, 32'h0005_5123);
    chk("R10 clean no write", {31'b0, rsp_perm_w}, 0);
    chk("R9 acc wb count", wr_n - w0, 1);
    chk("R9 acc wb data", last_wd, 32'h0005_5027);
    chk("R8 dir untouched", mem[32'h0001_0004], 32'h0002_0027);
    w0 = wr_n;
    xlate(32'h0040_3123, 1'b0, 1'b1);
    chk("R9 no change no wb", wr_n - w0, 0);
    xlate(32'h0040_3123, 1'b1, 1'b1);
    chk("R9 dirty wb", mem[32'h0002_000C], 32'h0005_5067);
    chk("R10 dirty grant", {31'b0, rsp_perm_w}, 1);
    stall = 0;
  endtask

  task automatic t_dir_acc;
    int w0;
    mem[32'h0001_0008] = 32'h0003_0007;
    mem[32'h0003_0000] = 32'h0006_6067;
    w0 = wr_n;
    xlate(32'h0080_0456, 1'b1, 1'b1);
    chk("R8 dir acc wb", mem[32'h0001_0008], 32'h0003_0027);
    chk("R8 single wb", wr_n - w0, 1);
    chk("R3 pa2", rsp_pa, 32'h0006_6456);
    chk("R10 grant2", {31'b0, rsp_perm_w}, 1);
  endtask

  task automatic t_notpres;
    xlate(32'h0140_0000, 1'b0, 1'b1);
    chk("R4 dir np fault", {31'b0, got_fault}, 1);
    chk("R4 dir np code", rsp_ecode, 3'b100);
    chk("R4 fault va", rsp_fault_va, 32'h0140_0000);
    mem[32'h0001_0018] = 32'h0003_5027;
    xlate(32'h0180_2000, 1'b1, 1'b0);
    chk("R4 tbl np code", {28'b0, got_fault, rsp_ecode}, 32'h0000_000A);
    chk("R4 fault va2", rsp_fault_va, 32'h0180_2000);
  endtask

  task automatic t_rights;
    mem[32'h0001_001C] = 32'h0004_0023;
    mem[32'h0004_0000] = 32'h0007_7067;
    xlate(32'h01C0_0ABC, 1'b0, 1'b1);
    chk("R6 user bit merge", {28'b0, got_fault, rsp_ecode}, 32'h0000_000D);
    xlate(32'h01C0_0ABC, 1'b0, 1'b0);
    chk("R6 sup ok pa", rsp_pa, 32'h0007_7ABC);
    mem[32'h0001_0020] = 32'h0004_1025;
    mem[32'h0004_1000] = 32'h0007_8067;
    xlate(32'h0200_0010, 1'b1, 1'b1);
    chk("R6 rw merge fault", {28'b0, got_fault, rsp_ecode}, 32'h0000_000F);
    cfg_wp = 1;
    xlate(32'h0200_0010, 1'b1, 1'b0);
    chk("R7 wp fault", {28'b0, got_fault, rsp_ecode}, 32'h0000_000B);
    cfg_wp = 0;
    xlate(32'h0200_0010, 1'b1, 1'b0);
    chk("R7 wp off ok", {31'b0, got_done}, 1);
    chk("R7 pa", rsp_pa, 32'h0007_8010);
    chk("R10 sup grant", {31'b0, rsp_perm_w}, 1);
  endtask

  task automatic t_big;
    mem[32'h0001_0024] = 32'h0C00_0087;
    cfg_big_en = 1;
    xlate(32'h0240_1234, 1'b1, 1'b1);
    chk("R5 big pa", rsp_pa, 32'h0C00_1234);
    chk("R5 big flag", {31'b0, rsp_big}, 1);
    chk("R5 one fetch", rd_n, 1);
    chk("R9 big wb", mem[32'h0001_0024], 32'h0C00_00E7);
    cfg_big_en = 0;
    xlate(32'h0240_1234, 1'b0, 1'b0);
    chk("R5 ps ignored tbl", rd_log[1], 32'h0C00_0004);
    chk("R5 ps ignored fault", {28'b0, got_fault, rsp_ecode}, 32'h0000_0008);
  endtask

  task automatic t_mask;
    cfg_root = 32'h0011_0000; cfg_a20_mask = ~(32'h1 << 20);
    xlate(32'h0040_3123, 1'b0, 1'b1);
    chk("R2 masked dir addr", rd_log[0], 32'h0001_0004);
    chk("R3 masked pa", rsp_pa, 32'h0005_5123);
    cfg_root = 32'h0001_0000; cfg_a20_mask = 32'hFFFF_FFFF;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_flat();
    t_small();
    t_dir_acc();
    t_notpres();
    t_rights();
    t_big();
    t_mask();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule